// File: doc/BRIEF.md
# Serial Video Link Character Unstuffer

This block sits behind the clock and data recovery of a three-lane serial video link. Each lane carries one 10-bit character per link-clock period, sent least significant bit first. The block runs on the bit clock, which is ten times the link clock. A lane-aligned `char_start` strobe marks the first bit of every character. The block frames the three lanes into characters and classifies each one as a control character, the fixed stuffing character, or a data character. It then decodes data characters into an 8-bit colour component per lane.

The link clock is held in its allowed range by sending each pixel as one real character followed by stuffing. The number of stuffing characters depends on a clock-to-pixel multiplier chosen by `mult_sel`. The block tracks the slot phase within each group and removes the stuffing. It emits one pixel (colour triple, or a blanking pixel carrying the sync flags) with a one-cycle `pix_valid` strobe. Control characters seen during blanking are what lock the slot phase. A character of the wrong kind in a slot sets a sticky error and drops lock until the next control character arrives.

Top module: `video_unstuffer`

## Requirements
- R1: Lane 0 carries blue, lane 1 green and lane 2 red. A character is the ten bits that start at the bit sampled with `char_start` high. Its first bit is bit 0 and its last bit is bit 9. A character is processed once the next `char_start` arrives.
- R2: A data character q decodes as follows. Let b = q[7:0], inverted when q[9] is 1. Then d[0] = b[0]. For i = 1 to 7, d[i] = b[i] XOR b[i-1] when q[8] is 1, and the XNOR of the same two bits when q[8] is 0. The decoded colour appears on the pixel outputs with `pix_de` = 1.
- R3: The lane-0 codes 0x354, 0x0AB, 0x154 and 0x2AB are control characters. They carry {vsync,hsync} = 00, 01, 10 and 11 respectively. Each produces a blanking pixel with `pix_de` = 0, all colour outputs 0 and the new sync values. The sync outputs hold their last control value through data pixels.
- R4: The stuffing character is 0x07A. With `mult_sel` = 00, every character is a pixel slot.
- R5: With `mult_sel` = 01, slots repeat as pixel, stuffing. Stuffing characters in stuffing slots produce no output.
- R6: With `mult_sel` = 10, slots repeat as pixel, stuffing, stuffing, stuffing. `mult_sel` = 11 behaves as 00. `mult_sel` only changes while `rst` is high.
- R7: A lane-0 control character always counts as the pixel slot of a new group, even in the middle of a group, and does not raise an error.
- R8: After reset, no pixel is emitted until the first lane-0 control character.
- R9: A stuffing character on any lane in a pixel slot, or a non-stuffing character on any lane in a stuffing slot, sets `stuff_err`. The flag stays set until reset. After such an error, pixels are suppressed until the next lane-0 control character.
- R10: `pix_valid` is high for exactly one clock per emitted pixel. All pixel outputs are registered and hold until the next pixel.
- R11: While `rst` is high and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, ten times the link clock |
| rst | input | 1 | Synchronous active-high reset |
| char_start | input | 1 | High on the first bit of each character, aligned on all lanes |
| ser_in | input | 3 | One serial bit per lane (0 blue, 1 green, 2 red) |
| mult_sel | input | 2 | Clock-to-pixel multiplier: 00 1x, 01 2x, 10 4x, 11 1x |
| pix_valid | output | 1 | One-cycle strobe per emitted pixel |
| pix_de | output | 1 | 1 for a colour pixel, 0 for a blanking pixel |
| pix_hsync | output | 1 | Horizontal sync from the latest control character |
| pix_vsync | output | 1 | Vertical sync from the latest control character |
| pix_red | output | 8 | Decoded lane-2 colour |
| pix_green | output | 8 | Decoded lane-1 colour |
| pix_blue | output | 8 | Decoded lane-0 colour |
| stuff_err | output | 1 | Sticky slot-mismatch flag |

## Verification
The bench feeds all 256 byte values through every lane, under all four inversion and XOR/XNOR encoding variants. A swapped bit order, a wrong invert step or a wrong XNOR branch would therefore corrupt some pixels. Each multiplier is run with clean groups, and a control character is injected in the middle of a 4x group. A tracker that failed to restart its phase there would flag a false error or drop a later pixel. Data sent before the first control character checks that an unlocked design stays silent. A stuffing character in a pixel slot, and data in a stuffing slot, check that the error stays set through later clean traffic and that the pixels in between are discarded rather than emitted with the wrong phase.

// File: rtl/video_unstuffer_pkg.sv
`timescale 1ns/1ps
package video_unstuffer_pkg;
  localparam int CHAR_W = 10;
  localparam int BYTE_W = 8;
  localparam logic [CHAR_W-1:0] STUFF_CODE = 10'h07A;

  typedef enum logic [1:0] {
    MUL_1X = 2'b00,
    MUL_2X = 2'b01,
    MUL_4X = 2'b10,
    MUL_RSV = 2'b11
  } mul_e;

  // Returns {hit, vsync, hsync} for a blanking character.
  function automatic logic [2:0] ctrl_lookup(input logic [CHAR_W-1:0] w);
    logic [2:0] r;
    case (w)
      10'h354: r = 3'b100;
      10'h0AB: r = 3'b101;
      10'h154: r = 3'b110;
      10'h2AB: r = 3'b111;
      default: r = 3'b000;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/vu_deser.sv
`timescale 1ns/1ps
module vu_deser #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ser_bit,
  input  logic          char_start,
  output logic [CW-1:0] word,
  output logic          word_v
);
  logic [CW-1:0] shreg;
  logic          primed;

  // Right shift: the first bit received ends up in bit 0.
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      primed <= 1'b0;
      word   <= '0;
      word_v <= 1'b0;
    end else begin
      shreg  <= {ser_bit, shreg[CW-1:1]};
      word_v <= 1'b0;
      if (char_start) begin
        primed <= 1'b1;
        word_v <= primed;
        if (primed) word <= shreg;
      end
    end
  end

  // R1: characters are at least two cycles apart
  a_r1_word_gap: assert property (@(posedge clk) disable iff (rst)
    word_v |=> !word_v);
endmodule

// File: rtl/vu_lane_decode.sv
`timescale 1ns/1ps
module vu_lane_decode
  import video_unstuffer_pkg::*;
#(
  parameter int CW = CHAR_W,
  parameter int DW = BYTE_W
) (
  input  logic [CW-1:0] word,
  output logic          is_stuff,
  output logic [DW-1:0] data
);
  logic [DW-1:0] base;

  always_comb begin
    is_stuff = (word == STUFF_CODE);
    base     = word[CW-1] ? ~word[DW-1:0] : word[DW-1:0];
    data[0]  = base[0];
    for (int i = 1; i < DW; i++) begin
      data[i] = word[CW-2] ? (base[i] ^ base[i-1]) : ~(base[i] ^ base[i-1]);
    end
  end
endmodule

// File: rtl/vu_slot_ctrl.sv
`timescale 1ns/1ps
module vu_slot_ctrl
  import video_unstuffer_pkg::*;
#(
  parameter int PHW = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       word_v,
  input  logic [1:0] mode,
  input  logic       lane0_ctrl,
  input  logic       any_stuff,
  input  logic       all_stuff,
  output logic       take,
  output logic       take_blank,
  output logic       err_flag
);
  logic [PHW-1:0] phase;
  logic [PHW-1:0] last_slot;
  logic           locked;
  logic           bad;

  always_comb begin
    case (mode)
      MUL_2X:  last_slot = PHW'(1);
      MUL_4X:  last_slot = PHW'(3);
      default: last_slot = '0;
    endcase
  end

  always_comb begin
    take       = 1'b0;
    take_blank = 1'b0;
    bad        = 1'b0;
    if (word_v) begin
      if (lane0_ctrl) begin
        take       = 1'b1;
        take_blank = 1'b1;
      end else if (locked) begin
        if (phase == '0) begin
          if (any_stuff) bad = 1'b1;
          else           take = 1'b1;
        end else if (!all_stuff) begin
          bad = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      locked   <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (bad) err_flag <= 1'b1;
      if (word_v) begin
        if (lane0_ctrl) begin
          locked <= 1'b1;
          phase  <= (last_slot == '0) ? '0 : PHW'(1);
        end else if (locked) begin
          if (bad) begin
            locked <= 1'b0;
            phase  <= '0;
          end else begin
            phase <= (phase == last_slot) ? '0 : phase + PHW'(1);
          end
        end
      end
    end
  end

  // R4: single-slot groups never leave phase 0
  a_r4_phase_1x: assert property (@(posedge clk) disable iff (rst)
    (mode == MUL_1X || mode == MUL_RSV) |-> phase == '0);
  // R5: two-slot groups use phases 0 and 1 only
  a_r5_phase_2x: assert property (@(posedge clk) disable iff (rst)
    (mode == MUL_2X) |-> phase <= PHW'(1));
  // R9: a detected mismatch drops lock
  a_r9_drop_lock: assert property (@(posedge clk) disable iff (rst)
    bad |=> !locked);
endmodule

// File: rtl/video_unstuffer.sv
`timescale 1ns/1ps
module video_unstuffer
  import video_unstuffer_pkg::*;
#(
  parameter int CW  = CHAR_W,
  parameter int DW  = BYTE_W,
  parameter int PHW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_start,
  input  logic [2:0]    ser_in,
  input  logic [1:0]    mult_sel,
  output logic          pix_valid,
  output logic          pix_de,
  output logic          pix_hsync,
  output logic          pix_vsync,
  output logic [DW-1:0] pix_red,
  output logic [DW-1:0] pix_green,
  output logic [DW-1:0] pix_blue,
  output logic          stuff_err
);
  localparam int NL = 3;

  logic [CW-1:0] lane_word [NL];
  logic [DW-1:0] lane_data [NL];
  logic [NL-1:0] lane_v;
  logic [NL-1:0] lane_stuff;
  logic [2:0]    ctrl_info;
  logic          take, take_blank;

  for (genvar ln = 0; ln < NL; ln++) begin : g_lane
    vu_deser #(.CW(CW)) u_deser (
      .clk        (clk),
      .rst        (rst),
      .ser_bit    (ser_in[ln]),
      .char_start (char_start),
      .word       (lane_word[ln]),
      .word_v     (lane_v[ln])
    );
    vu_lane_decode #(.CW(CW), .DW(DW)) u_dec (
      .word     (lane_word[ln]),
      .is_stuff (lane_stuff[ln]),
      .data     (lane_data[ln])
    );
  end

  assign ctrl_info = ctrl_lookup(lane_word[0]);

  vu_slot_ctrl #(.PHW(PHW)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .word_v     (&lane_v),
    .mode       (mult_sel),
    .lane0_ctrl (ctrl_info[2]),
    .any_stuff  (|lane_stuff),
    .all_stuff  (&lane_stuff),
    .take       (take),
    .take_blank (take_blank),
    .err_flag   (stuff_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_de    <= 1'b0;
      pix_hsync <= 1'b0;
      pix_vsync <= 1'b0;
      pix_red   <= '0;
      pix_green <= '0;
      pix_blue  <= '0;
    end else begin
      pix_valid <= take;
      if (take) begin
        pix_de <= !take_blank;
        if (take_blank) begin
          pix_vsync <= ctrl_info[1];
          pix_hsync <= ctrl_info[0];
          pix_red   <= '0;
          pix_green <= '0;
          pix_blue  <= '0;
        end else begin
          pix_red   <= lane_data[2];
          pix_green <= lane_data[1];
          pix_blue  <= lane_data[0];
        end
      end
    end
  end

  // R10: one-cycle strobe per pixel
  a_r10_single_strobe: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);
  // R3: blanking pixels carry black
  a_r3_blank_black: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_de) |-> (pix_red == '0 && pix_green == '0 && pix_blue == '0));
  // R9: error flag is sticky
  a_r9_sticky_err: assert property (@(posedge clk) disable iff (rst)
    stuff_err |=> stuff_err);
  // R10: outputs hold between strobes
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> $stable(pix_red) && $stable(pix_de));
endmodule

// File: tb/tb_video_unstuffer.sv
`timescale 1ns/1ps
module tb_video_unstuffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       char_start = 1'b0;
  logic [2:0] ser_in = 3'b000;
  logic [1:0] mult_sel = 2'b00;
  logic       pix_valid, pix_de, pix_hsync, pix_vsync, stuff_err;
  logic [7:0] pix_red, pix_green, pix_blue;

  localparam logic [9:0] F_CODE = 10'h07A;
  localparam logic [9:0] K0 = 10'h354, K1 = 10'h0AB, K2 = 10'h154, K3 = 10'h2AB;

  video_unstuffer dut (
    .clk(clk), .rst(rst), .char_start(char_start), .ser_in(ser_in),
    .mult_sel(mult_sel), .pix_valid(pix_valid), .pix_de(pix_de),
    .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_red(pix_red),
    .pix_green(pix_green), .pix_blue(pix_blue), .stuff_err(stuff_err)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [26:0] expq [0:1023];
  int wr = 0, rd = 0;
  string req = "R11";
  logic prev_v = 1'b0;
  logic cur_hs = 1'b0, cur_vs = 1'b0;
  bit reported = 0;

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  task automatic check(input bit ok, input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rst) prev_v = 1'b0;
    else begin
      if (pix_valid) begin
        check(!prev_v, "R10", "strobe longer than one cycle", 32'(prev_v), 0);
        if (rd >= wr)
          check(0, req, "unexpected pixel", {5'd0, pix_de, pix_hsync, pix_vsync,
                pix_red, pix_green, pix_blue}, 0);
        else begin
          check({pix_de, pix_hsync, pix_vsync, pix_red, pix_green, pix_blue} === expq[rd],
                req, "pixel", {5'd0, pix_de, pix_hsync, pix_vsync, pix_red, pix_green, pix_blue},
                {5'd0, expq[rd]});
          rd++;
        end
      end
      prev_v = pix_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R10", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  function automatic logic [9:0] enc(input logic [7:0] d, input logic [1:0] v);
    logic [7:0] b;
    logic [9:0] q;
    b[0] = d[0];
    for (int i = 1; i < 8; i++) b[i] = v[1] ? (b[i-1] ^ d[i]) : ~(b[i-1] ^ d[i]);
    q = {v[0], v[1], v[0] ? ~b : b};
    if (q == F_CODE || q == K0 || q == K1 || q == K2 || q == K3)
      q = {~q[9], q[8], ~q[7:0]};
    return q;
  endfunction

  task automatic send_word(input logic [9:0] w0, input logic [9:0] w1, input logic [9:0] w2);
    for (int b = 0; b < 10; b++) begin
      @(negedge clk);
      char_start = (b == 0);
      ser_in = {w2[b], w1[b], w0[b]};
    end
  endtask

  task automatic send_data(input logic [7:0] r, input logic [7:0] g, input logic [7:0] bl,
                           input logic [1:0] v, input bit expect_pix);
    send_word(enc(bl, v), enc(g, v + 2'd1), enc(r, v + 2'd2));
    if (expect_pix) begin expq[wr] = {1'b1, cur_hs, cur_vs, r, g, bl}; wr++; end
  endtask

  task automatic send_ctrl(input logic [1:0] c);
    logic [9:0] k;
    case (c)
      2'd0: k = K0; 2'd1: k = K1; 2'd2: k = K2; default: k = K3;
    endcase
    send_word(k, K0, K0);
    cur_hs = c[0];
    cur_vs = c[1];
    expq[wr] = {1'b0, cur_hs, cur_vs, 24'd0};
    wr++;
  endtask

  task automatic send_fill();
    send_word(F_CODE, F_CODE, F_CODE);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mult_sel = m; char_start = 1'b0; ser_in = 3'b000;
    wr = 0; rd = 0; cur_hs = 1'b0; cur_vs = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic end_scn(input string r, input bit exp_err);
    @(negedge clk); char_start = 1'b1; ser_in = 3'b000;
    @(negedge clk); char_start = 1'b0;
    repeat (4) @(negedge clk);
    check(rd == wr, r, "pixel count", 32'(rd), 32'(wr));
    check(stuff_err == exp_err, r, "stuff_err", 32'(stuff_err), 32'(exp_err));
  endtask

  initial begin
    // R11: reset state
    do_reset(2'b00);
    check({pix_valid, pix_de, pix_hsync, pix_vsync, stuff_err} == 5'd0 &&
          {pix_red, pix_green, pix_blue} == 24'd0, "R11", "reset outputs",
          {pix_valid, pix_de, pix_hsync, pix_vsync, stuff_err}, 0);

    // R1 R2 R4: 1x, all byte values in every encoding variant
    req = "R2"; do_reset(2'b00);
    send_ctrl(2'd1);
    for (int v = 0; v < 256; v++)
      send_data(8'(v), 8'(v) ^ 8'h5A, ~8'(v), 2'(v), 1'b1);
    end_scn("R1", 1'b0);

    // R3: every control code with data between
    req = "R3"; do_reset(2'b00);
    for (int c = 0; c < 4; c++) begin
      send_ctrl(2'(c));
      send_data(8'h11 * 8'(c + 1), 8'hC3, 8'h3C, 2'(c), 1'b1);
    end
    end_scn("R3", 1'b0);

    // R5: 2x stuffing
    req = "R5"; do_reset(2'b01);
    send_ctrl(2'd2); send_fill();
    for (int i = 0; i < 8; i++) begin
      send_data(8'(i * 29), 8'(i * 7 + 1), 8'(255 - i), 2'(i), 1'b1);
      send_fill();
    end
    end_scn("R5", 1'b0);

    // R6: 4x stuffing
    req = "R6"; do_reset(2'b10);
    send_ctrl(2'd3); send_fill(); send_fill(); send_fill();
    for (int i = 0; i < 6; i++) begin
      send_data(8'(i * 41), 8'(i + 100), 8'(i * 3), 2'(i), 1'b1);
      send_fill(); send_fill(); send_fill();
    end
    end_scn("R6", 1'b0);

    // R6: code 11 acts as 1x
    req = "R6"; do_reset(2'b11);
    send_ctrl(2'd0);
    for (int i = 0; i < 5; i++) send_data(8'(i + 200), 8'(i), 8'(i * 50), 2'(i), 1'b1);
    end_scn("R6", 1'b0);

    // R7: control in the middle of a 4x group restarts the phase
    req = "R7"; do_reset(2'b10);
    send_ctrl(2'd0); send_fill();
    send_ctrl(2'd1); send_fill(); send_fill(); send_fill();
    send_data(8'hA5, 8'h5A, 8'hFF, 2'd2, 1'b1);
    send_fill(); send_fill(); send_fill();
    end_scn("R7", 1'b0);

    // R8: no output before lock
    req = "R8"; do_reset(2'b00);
    for (int i = 0; i < 4; i++) send_data(8'(i), 8'(i), 8'(i), 2'(i), 1'b0);
    send_ctrl(2'd2);
    send_data(8'h01, 8'h80, 8'h7E, 2'd3, 1'b1);
    send_data(8'h00, 8'hFF, 8'h10, 2'd0, 1'b1);
    end_scn("R8", 1'b0);

    // R9: stuffing in a pixel slot (2x), sticky flag, relock
    req = "R9"; do_reset(2'b01);
    send_ctrl(2'd0); send_fill();
    send_data(8'h12, 8'h34, 8'h56, 2'd1, 1'b1); send_fill();
    send_fill();
    send_data(8'h9A, 8'hBC, 8'hDE, 2'd2, 1'b0); send_fill();
    send_data(8'h21, 8'h43, 8'h65, 2'd3, 1'b0);
    send_ctrl(2'd3); send_fill();
    send_data(8'hF0, 8'h0F, 8'h99, 2'd0, 1'b1); send_fill();
    end_scn("R9", 1'b1);

    // R9: data in a stuffing slot (4x)
    req = "R9"; do_reset(2'b10);
    send_ctrl(2'd1); send_fill();
    send_data(8'h77, 8'h66, 8'h55, 2'd1, 1'b0);
    send_data(8'h44, 8'h33, 8'h22, 2'd2, 1'b0);
    send_ctrl(2'd2); send_fill(); send_fill(); send_fill();
    send_data(8'h10, 8'h20, 8'h30, 2'd3, 1'b1);
    send_fill(); send_fill(); send_fill();
    end_scn("R9", 1'b1);

    summary();
    $finish;
  end
endmodule